// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block translates physical addresses from a CPU into device selections. It holds a bank of programmable windows. Each window is enabled on its own and carries a base, a power-of-two style size, a 4-bit target identifier and an 8-bit attribute tag. For every request address the decoder reports whether an enabled window covers it, which window that is, the window's target and attribute, and the address to forward to the device.

Only the first group of windows can relocate the address. The forwarded address of such a window is built from a programmed remap base and the offset of the request inside the window. All other windows pass the address through unchanged. A 32-bit register port with a single write strobe and a combinational read path programs the windows. The register map is irregular: the relocating windows use a wide stride, a reserved gap follows them, and the remaining windows are packed at a narrow stride.

The decode path is purely combinational from the request address and the window registers. Register writes take effect at the next rising clock edge.

Top module: `addr_window_decoder`

## Requirements
- R1: After the asynchronous active-low reset, every register reads as zero and every request address reports a miss.
- R2: Window i below 8 occupies byte offset 16*i: control at +0x0, base at +0x4, remap low at +0x8, remap high at +0xC. Window i from 8 to 19 occupies byte offset 0x90+8*(i-8): control at +0x0, base at +0x4.
- R3: The control register has the enable in bit 0, the target in bits 7:4, the attribute in bits 15:8 and the window size minus one, in 64 KB units, in bits 31:16. Bits 3:1 read as zero.
- R4: The base register holds address bits 31:16 in bits 31:16 and address bits 35:32 in bits 3:0. All other bits read as zero.
- R5: In remap low only bits 31:16 are kept, and they form remap address bits 31:16. In remap high only bits 3:0 are kept, and they form remap address bits 35:32.
- R6: The gap at 0x80-0x8F, offsets 0xF0 and above, and offsets that are not word aligned read as zero, and writes to them change nothing.
- R7: A window matches when it is enabled and the request address equals its base on every bit above the size mask. The size mask is {control[31:16], 16 ones}.
- R8: On a hit in a window below 8, the forwarded address is the remap base ORed with (request address AND size mask).
- R9: On a hit in a window of index 8 or above, the forwarded address equals the request address.
- R10: A window with its enable bit clear never matches, whatever its base holds. Writing zero to its control register takes it out of the decode.
- R11: When several enabled windows match, the one with the lowest index is reported.
- R12: On a miss, miss is 1 and hit is 0, the target, attribute and index are 0, and the forwarded address equals the request address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| req_addr | input | 36 | Request physical address |
| hit | output | 1 | An enabled window covers req_addr |
| miss | output | 1 | No enabled window covers req_addr |
| win_idx | output | 5 | Index of the selected window |
| tgt | output | 4 | Target identifier of the selected window |
| attr | output | 8 | Attribute of the selected window |
| xlat_addr | output | 36 | Forwarded address |

## Verification
Directed patterns place an address inside a relocating window, inside a pass-through window that overlaps it, in the same range after the first window is cleared, and far from any window. Together they separate the remap arithmetic, lowest-index priority, the disable path and miss reporting. A sweep that writes all ones to every offset in the register space tells the per-offset storage masks and the reserved ranges apart. Random window sets with mixed sizes, probed at addresses drawn inside chosen windows and at fully random addresses, exercise the mask comparison and the priority with many overlaps. Each result is compared against a model of the register image kept by the bench.

// File: rtl/addr_window_decoder.sv
module addr_window_decoder #(
  parameter int NUM_WIN   = 20,
  parameter int NUM_REMAP = 8,
  parameter int REG_AW    = 8,
  parameter int PA_W      = 36
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_we,
  input  logic [REG_AW-1:0]          reg_addr,
  input  logic [31:0]                reg_wdata,
  output logic [31:0]                reg_rdata,
  input  logic [PA_W-1:0]            req_addr,
  output logic                       hit,
  output logic                       miss,
  output logic [$clog2(NUM_WIN)-1:0] win_idx,
  output logic [3:0]                 tgt,
  output logic [7:0]                 attr,
  output logic [PA_W-1:0]            xlat_addr
);
  localparam int WIN_W      = $clog2(NUM_WIN);
  localparam int HI_W       = PA_W - 32;
  localparam int PACK_START = NUM_REMAP * 16 + 16;
  localparam logic [31:0] CTRL_KEEP = 32'hFFFF_FFF1;
  localparam logic [31:0] BASE_KEEP = {16'hFFFF, {(16-HI_W){1'b0}}, {HI_W{1'b1}}};
  localparam logic [31:0] RLO_KEEP  = 32'hFFFF_0000;
  localparam logic [31:0] RHI_KEEP  = {{(32-HI_W){1'b0}}, {HI_W{1'b1}}};

  function automatic int ctrl_off(int i);
    return (i < NUM_REMAP) ? i * 16 : PACK_START + (i - NUM_REMAP) * 8;
  endfunction

  logic [31:0] ctrl_q  [NUM_WIN];
  logic [31:0] base_q  [NUM_WIN];
  logic [31:0] rlo_q   [NUM_REMAP];
  logic [31:0] rhi_q   [NUM_REMAP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WIN; i++) begin
        ctrl_q[i] <= '0;
        base_q[i] <= '0;
      end
      for (int i = 0; i < NUM_REMAP; i++) begin
        rlo_q[i] <= '0;
        rhi_q[i] <= '0;
      end
    end else if (reg_we) begin
      for (int i = 0; i < NUM_WIN; i++) begin
        if (reg_addr == REG_AW'(ctrl_off(i)))     ctrl_q[i] <= reg_wdata & CTRL_KEEP;
        if (reg_addr == REG_AW'(ctrl_off(i) + 4)) base_q[i] <= reg_wdata & BASE_KEEP;
      end
      for (int i = 0; i < NUM_REMAP; i++) begin
        if (reg_addr == REG_AW'(ctrl_off(i) + 8))  rlo_q[i] <= reg_wdata & RLO_KEEP;
        if (reg_addr == REG_AW'(ctrl_off(i) + 12)) rhi_q[i] <= reg_wdata & RHI_KEEP;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (reg_addr == REG_AW'(ctrl_off(i)))     reg_rdata = ctrl_q[i];
      if (reg_addr == REG_AW'(ctrl_off(i) + 4)) reg_rdata = base_q[i];
    end
    for (int i = 0; i < NUM_REMAP; i++) begin
      if (reg_addr == REG_AW'(ctrl_off(i) + 8))  reg_rdata = rlo_q[i];
      if (reg_addr == REG_AW'(ctrl_off(i) + 12)) reg_rdata = rhi_q[i];
    end
  end

  logic [PA_W-1:0] mask   [NUM_WIN];
  logic [PA_W-1:0] wbase  [NUM_WIN];
  logic [NUM_WIN-1:0] match;

  genvar g;
  generate
    for (g = 0; g < NUM_WIN; g++) begin : g_win
      assign mask[g]  = {{(PA_W-32){1'b0}}, ctrl_q[g][31:16], 16'hFFFF};
      assign wbase[g] = {base_q[g][HI_W-1:0], base_q[g][31:16], 16'h0000};
      assign match[g] = ctrl_q[g][0] && (((req_addr ^ wbase[g]) & ~mask[g]) == '0);
    end
  endgenerate

  always_comb begin
    hit       = 1'b0;
    win_idx   = '0;
    tgt       = '0;
    attr      = '0;
    xlat_addr = req_addr;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit     = 1'b1;
        win_idx = WIN_W'(i);
        tgt     = ctrl_q[i][7:4];
        attr    = ctrl_q[i][15:8];
        if (i < NUM_REMAP)
          xlat_addr = {rhi_q[i % NUM_REMAP][HI_W-1:0], rlo_q[i % NUM_REMAP][31:16], 16'h0000}
                      | (req_addr & mask[i]);
        else
          xlat_addr = req_addr;
      end
    end
  end

  assign miss = ~hit;
endmodule

// File: rtl/addr_window_decoder_chk.sv
module addr_window_decoder_chk #(
  parameter int NUM_WIN   = 20,
  parameter int NUM_REMAP = 8,
  parameter int REG_AW    = 8,
  parameter int PA_W      = 36
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [REG_AW-1:0]          reg_addr,
  input logic [31:0]                reg_rdata,
  input logic [PA_W-1:0]            req_addr,
  input logic                       hit,
  input logic                       miss,
  input logic [$clog2(NUM_WIN)-1:0] win_idx,
  input logic [3:0]                 tgt,
  input logic [7:0]                 attr,
  input logic [PA_W-1:0]            xlat_addr
);
  localparam int GAP_LO = NUM_REMAP * 16;

  p_hit_or_miss_r12: assert property (@(posedge clk) disable iff (!rst_n)
    hit != miss);

  p_miss_clean_r12: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> (tgt == '0 && attr == '0 && win_idx == '0 && xlat_addr == req_addr));

  p_pass_through_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && int'(win_idx) >= NUM_REMAP) |-> xlat_addr == req_addr);

  p_idx_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> int'(win_idx) < NUM_WIN);

  p_gap_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(reg_addr) >= GAP_LO && int'(reg_addr) < GAP_LO + 16) |-> reg_rdata == '0);

  p_unaligned_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[1:0] != 2'b00) |-> reg_rdata == '0);

  p_reset_miss_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> miss);
endmodule

bind addr_window_decoder addr_window_decoder_chk #(
  .NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP), .REG_AW(REG_AW), .PA_W(PA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .req_addr(req_addr), .hit(hit), .miss(miss), .win_idx(win_idx),
  .tgt(tgt), .attr(attr), .xlat_addr(xlat_addr)
);

// File: tb/tb_addr_window_decoder.sv
module tb_addr_window_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [35:0] req_addr = '0;
  logic        hit, miss;
  logic [4:0]  win_idx;
  logic [3:0]  tgt;
  logic [7:0]  attr;
  logic [35:0] xlat_addr;

  int checks = 0;
  int errors = 0;
  logic [31:0] mdl [64];

  always #4 clk = ~clk;

  addr_window_decoder dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_addr(req_addr),
    .hit(hit), .miss(miss), .win_idx(win_idx), .tgt(tgt), .attr(attr),
    .xlat_addr(xlat_addr)
  );

  initial begin
    #1600000;
    checks++; errors++;
    $display("FAIL watchdog: run did not finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [31:0] keep_mask(int a);
    if (a[1:0] != 2'b00) return 32'h0;
    if (a < 128) begin
      case ((a >> 2) & 3)
        0: return 32'hFFFF_FFF1;
        1: return 32'hFFFF_000F;
        2: return 32'hFFFF_0000;
        default: return 32'h0000_000F;
      endcase
    end
    if (a < 144 || a >= 240) return 32'h0;
    return (((a - 144) >> 2) & 1) == 0 ? 32'hFFFF_FFF1 : 32'hFFFF_000F;
  endfunction

  function automatic int ctrl_at(int w);
    return w < 8 ? w * 16 : 144 + (w - 8) * 8;
  endfunction

  task automatic model_decode(input logic [35:0] a, output logic h, output logic [4:0] ix,
                              output logic [3:0] t, output logic [7:0] at, output logic [35:0] x);
    h = 0; ix = 0; t = 0; at = 0; x = a;
    for (int w = 0; w < 20; w++) begin
      logic [31:0] c, b;
      logic [35:0] m, bs, rb;
      c  = mdl[ctrl_at(w) >> 2];
      b  = mdl[(ctrl_at(w) + 4) >> 2];
      m  = {4'h0, c[31:16], 16'hFFFF};
      bs = {b[3:0], b[31:16], 16'h0};
      if (!h && c[0] && (((a ^ bs) & ~m) == 0)) begin
        h = 1; ix = 5'(w); t = c[7:4]; at = c[15:8];
        if (w < 8) begin
          rb = {mdl[(ctrl_at(w) + 12) >> 2][3:0], mdl[(ctrl_at(w) + 8) >> 2][31:16], 16'h0};
          x = rb | (a & m);
        end
      end
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = 8'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
    mdl[a >> 2] = (mdl[a >> 2] & ~keep_mask(a)) | (d & keep_mask(a));
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_read(input int a, input string tag);
    logic [31:0] e;
    e = (a[1:0] == 2'b00) ? (mdl[a >> 2] & keep_mask(a)) : 32'h0;
    reg_addr = 8'(a);
    #1;
    chk(reg_rdata == e, tag, 64'(reg_rdata), 64'(e));
  endtask

  task automatic chk_dec(input logic [35:0] a, input string tag);
    logic h; logic [4:0] ix; logic [3:0] t; logic [7:0] at; logic [35:0] x;
    model_decode(a, h, ix, t, at, x);
    req_addr = a;
    #1;
    chk({hit, miss, win_idx, tgt, attr, xlat_addr} == {h, ~h, ix, t, at, x}, tag,
        {7'h0, hit, miss, win_idx, tgt, attr, xlat_addr}, {7'h0, h, ~h, ix, t, at, x});
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 64; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 256; a += 4) chk_read(a, "R1 reset read");
    chk_dec(36'h0_0000_0000, "R1 reset decode");
    chk_dec(36'hF_FFFF_FFFF, "R1 reset decode high");

    // R2 R3 R4 R5 R6: all-ones sweep, then readback
    for (int a = 0; a < 256; a += 4) wr(a, 32'hFFFF_FFFF);
    wr(8'h81, 32'hFFFF_FFFF);
    @(negedge clk);
    for (int a = 0; a < 256; a += 4)
      chk_read(a, keep_mask(a) == 0 ? "R6 reserved offset" : "R2 R3 R4 R5 field readback");
    chk_read(8'h82, "R6 unaligned read");
    for (int a = 0; a < 256; a += 4) wr(a, 32'h0);
    @(negedge clk);
    chk_dec(36'h1_2345_6789, "R10 zeroed windows miss");

    // R7 R8: relocating window 3, 1 MB, target 5, attr A3
    wr(ctrl_at(3),      32'h000F_A351);
    wr(ctrl_at(3) + 4,  32'h1230_0002);
    wr(ctrl_at(3) + 8,  32'h8000_0000);
    wr(ctrl_at(3) + 12, 32'h0000_0000);
    @(negedge clk);
    chk_dec(36'h2_123A_BCDE, "R8 remap hit");
    chk(xlat_addr == 36'h0_800A_BCDE, "R8 remap literal", 64'(xlat_addr), 64'h0_800A_BCDE);
    chk_dec(36'h2_1240_0000, "R7 just above window");
    chk_dec(36'h3_1230_0000, "R7 high bits differ");

    // R11: overlapping pass-through window 12, 16 MB, target 9
    wr(ctrl_at(12),     32'h00FF_4491);
    wr(ctrl_at(12) + 4, 32'h1200_0002);
    @(negedge clk);
    chk_dec(36'h2_123A_BCDE, "R11 lowest index wins");
    chk(win_idx == 5'd3, "R11 literal index", 64'(win_idx), 64'd3);
    chk_dec(36'h2_12F0_0010, "R9 pass-through hit");

    // R10: disable window 3 by zeroing control
    wr(ctrl_at(3), 32'h0);
    @(negedge clk);
    chk_dec(36'h2_123A_BCDE, "R10 disabled falls to next");
    chk(win_idx == 5'd12 && xlat_addr == 36'h2_123A_BCDE, "R9 R10 literal",
        {23'h0, win_idx, xlat_addr}, {23'h0, 5'd12, 36'h2_123A_BCDE});
    wr(ctrl_at(12), 32'h00FF_4490);
    @(negedge clk);
    chk_dec(36'h2_123A_BCDE, "R10 enable clear no match");
    chk(miss && tgt == 0 && attr == 0, "R12 miss tags", {61'h0, miss, 2'b0}, {61'h0, 1'b1, 2'b0});

    // Random windows and probes
    for (int it = 0; it < 30; it++) begin
      for (int w = 0; w < 20; w++) begin
        int k;
        logic [31:0] c;
        k = $urandom_range(0, 10);
        c = {16'((32'h1 << k) - 1), 8'($urandom), 4'($urandom), 3'b0, 1'($urandom_range(0, 2) != 0)};
        wr(ctrl_at(w), c);
        wr(ctrl_at(w) + 4, {4'($urandom) , 12'h0, 12'($urandom), 4'($urandom)});
        if (w < 8) begin
          wr(ctrl_at(w) + 8, $urandom);
          wr(ctrl_at(w) + 12, $urandom);
        end
      end
      @(negedge clk);
      for (int p = 0; p < 40; p++) begin
        int w;
        logic [31:0] c, b;
        logic [35:0] m, a;
        w = $urandom_range(0, 19);
        c = mdl[ctrl_at(w) >> 2];
        b = mdl[(ctrl_at(w) + 4) >> 2];
        m = {4'h0, c[31:16], 16'hFFFF};
        a = {$urandom, $urandom};
        if (p % 4 != 0) a = ({b[3:0], b[31:16], 16'h0} & ~m) | (a & m);
        chk_dec(a, "R7 R8 R9 R11 R12 random decode");
        @(negedge clk);
      end
      for (int p = 0; p < 8; p++) chk_read($urandom_range(0, 255), "R2 R6 random read");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule